// File: doc/BRIEF.md
# Comparator Interrupt Flag and Enable Registers

This block holds the interrupt state for five comparator event sources of a small microcontroller. It has two 8-bit special-function registers on a simple SFR bus. The mask register sits at address 0xB1 and the pending register at address 0xAC. Bit n of each register (n = 0..4) belongs to comparator n. Bits 7:5 are not implemented.

A comparator event is a one-cycle pulse that arrives already synchronized. It latches its pending bit only if the matching mask bit is 1. Software clears a pending bit by writing 0 to it. The interrupt controller clears every pending bit at once when it pulses its acknowledge. A single request line goes to the controller and stays high while any pending bit is 1.

There is no sequencing state in the block. Each pending bit is a set/clear register, and the set input has priority over the clear input. Once a bit is latched, the mask no longer affects it.

Top module: `cmpirq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_req` is 0.
- R2: A write at address 0xB1 stores `sfr_wdata[4:0]` as the mask. A read at 0xB1 returns the mask in bits 4:0, and bits 7:5 always read 0.
- R3: When `cmp_evt[n]` is high at a clock edge and mask bit n held 1 before that edge, pending bit n reads 1 from the next cycle onward. If the mask is written in the same cycle as the event, the old mask value is the one used.
- R4: A `cmp_evt[n]` pulse while mask bit n is 0 leaves pending bit n unchanged.
- R5: A write at address 0xAC clears every pending bit whose data bit is 0. Pending bits whose data bit is 1 keep their value, so a write can never set a pending bit.
- R6: A one-cycle `irq_ack` pulse clears all pending bits at the next edge.
- R7: If a pending bit is set by an event and cleared by a write or by `irq_ack` in the same cycle, the set wins and the bit reads 1 afterwards.
- R8: `irq_req` is 1 exactly when any pending bit is 1. Clearing mask bits does not clear or hide bits that are already pending.
- R9: `sfr_rdata` is 0x00 unless `sfr_rd` is high and the address is 0xB1 or 0xAC. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Combinational SFR read data |
| cmp_evt | input | 5 | One-cycle comparator event pulses, bit n = comparator n |
| irq_ack | input | 1 | One-cycle acknowledge from the interrupt controller |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a collision: an event pulse and a clear land on the same clock edge. The clear can come from a write of zero to the pending register or from an acknowledge. The bench has a single-cycle step task that drives the bus, the event lines and the acknowledge together on one falling edge, so both sources meet at the same rising edge. The same task also writes the mask in the same cycle as an event, which shows that the mask value held before the edge is the one that gates the event.

// File: rtl/cmpirq_pkg.sv
package cmpirq_pkg;
    localparam int unsigned CMP_COUNT   = 5;
    localparam int unsigned SFR_DATA_W  = 8;
    localparam int unsigned SFR_ADDR_W  = 8;
    localparam logic [7:0]  MASK_ADDR   = 8'hB1;
    localparam logic [7:0]  PEND_ADDR   = 8'hAC;

    typedef struct packed {
        logic mask_wr;
        logic pend_wr;
        logic mask_rd;
        logic pend_rd;
    } sfr_sel_t;
endpackage

// File: rtl/cmpirq_decode.sv
module cmpirq_decode
    import cmpirq_pkg::*;
#(
    parameter int unsigned  AW       = SFR_ADDR_W,
    parameter logic [AW-1:0] M_ADDR  = MASK_ADDR,
    parameter logic [AW-1:0] P_ADDR  = PEND_ADDR
) (
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output sfr_sel_t      sel
);
    logic hit_mask;
    logic hit_pend;

    always_comb begin
        hit_mask    = (addr == M_ADDR);
        hit_pend    = (addr == P_ADDR);
        sel.mask_wr = wr & hit_mask;
        sel.pend_wr = wr & hit_pend;
        sel.mask_rd = rd & hit_mask;
        sel.pend_rd = rd & hit_pend;
    end
endmodule

// File: rtl/cmpirq_mask_reg.sv
module cmpirq_mask_reg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_val,
    output logic [N-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_en) begin
            mask <= wr_val;
        end
    end
endmodule

// File: rtl/cmpirq_pend_reg.sv
module cmpirq_pend_reg #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend
);
    // One set/clear cell per source; set dominates clear
    for (genvar g = 0; g < N; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else if (set_vec[g]) begin
                pend[g] <= 1'b1;
            end else if (clr_vec[g]) begin
                pend[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmpirq_rdmux.sv
module cmpirq_rdmux
    import cmpirq_pkg::*;
#(
    parameter int unsigned N  = 5,
    parameter int unsigned DW = 8
) (
    input  sfr_sel_t      sel,
    input  logic [N-1:0]  mask,
    input  logic [N-1:0]  pend,
    output logic [DW-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (1'b1)
            sel.mask_rd: rdata[N-1:0] = mask;
            sel.pend_rd: rdata[N-1:0] = pend;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmpirq_ctrl.sv
module cmpirq_ctrl
    import cmpirq_pkg::*;
#(
    parameter int unsigned   N       = CMP_COUNT,
    parameter int unsigned   DW      = SFR_DATA_W,
    parameter int unsigned   AW      = SFR_ADDR_W,
    parameter logic [AW-1:0] M_ADDR  = MASK_ADDR,
    parameter logic [AW-1:0] P_ADDR  = PEND_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sfr_wr,
    input  logic          sfr_rd,
    input  logic [AW-1:0] sfr_addr,
    input  logic [DW-1:0] sfr_wdata,
    output logic [DW-1:0] sfr_rdata,
    input  logic [N-1:0]  cmp_evt,
    input  logic          irq_ack,
    output logic          irq_req
);
    localparam int unsigned UNUSED_W = DW - N;

    sfr_sel_t     sel;
    logic [N-1:0] mask_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;
    logic [UNUSED_W-1:0] wdata_hi_unused;

    assign wdata_hi_unused = sfr_wdata[DW-1:N];

    cmpirq_decode #(.AW(AW), .M_ADDR(M_ADDR), .P_ADDR(P_ADDR)) u_dec (
        .wr   (sfr_wr),
        .rd   (sfr_rd),
        .addr (sfr_addr),
        .sel  (sel)
    );

    cmpirq_mask_reg #(.N(N)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sel.mask_wr),
        .wr_val (sfr_wdata[N-1:0]),
        .mask   (mask_q)
    );

    always_comb begin
        set_vec = cmp_evt & mask_q;
        clr_vec = '0;
        if (sel.pend_wr) clr_vec = clr_vec | ~sfr_wdata[N-1:0];
        if (irq_ack)     clr_vec = '1;
    end

    cmpirq_pend_reg #(.N(N)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend_q)
    );

    cmpirq_rdmux #(.N(N), .DW(DW)) u_rd (
        .sel   (sel),
        .mask  (mask_q),
        .pend  (pend_q),
        .rdata (sfr_rdata)
    );

    assign irq_req = |pend_q;
endmodule

// File: rtl/cmpirq_ctrl_chk.sv
module cmpirq_ctrl_chk #(
    parameter int unsigned   N      = 5,
    parameter int unsigned   DW     = 8,
    parameter int unsigned   AW     = 8,
    parameter logic [AW-1:0] P_ADDR = 8'hAC
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sfr_rd,
    input logic [AW-1:0] sfr_addr,
    input logic [DW-1:0] sfr_rdata,
    input logic [N-1:0]  cmp_evt,
    input logic          irq_ack,
    input logic          irq_req,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  pend_q
);
    p_hi_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rdata[DW-1:N] == '0);

    p_gated_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        |(cmp_evt & mask_q) |=> ((pend_q & $past(cmp_evt & mask_q)) == $past(cmp_evt & mask_q)));

    p_no_ungated_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |(cmp_evt & ~mask_q) |=> ((pend_q & ~$past(pend_q) & ~$past(cmp_evt & mask_q)) == '0));

    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ((pend_q & ~$past(cmp_evt & mask_q)) == '0));

    p_req_matches_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && sfr_addr == P_ADDR) |-> (irq_req == |sfr_rdata[N-1:0]));

    p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_rd |-> (sfr_rdata == '0));
endmodule

bind cmpirq_ctrl cmpirq_ctrl_chk #(.N(N), .DW(DW), .AW(AW), .P_ADDR(P_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_rd    (sfr_rd),
    .sfr_addr  (sfr_addr),
    .sfr_rdata (sfr_rdata),
    .cmp_evt   (cmp_evt),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
);

// File: tb/sim_cmpirq_ctrl.sv
`timescale 1ns/1ps
module sim_cmpirq_ctrl;
    localparam logic [7:0] A_MASK = 8'hB1;
    localparam logic [7:0] A_PEND = 8'hAC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_wr = 1'b0;
    logic       sfr_rd = 1'b0;
    logic [7:0] sfr_addr = '0;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic [4:0] cmp_evt = '0;
    logic       irq_ack = 1'b0;
    logic       irq_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cmpirq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .cmp_evt(cmp_evt), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Drive one cycle of inputs on a falling edge, let them be sampled, return idle
    task automatic step(input logic wr, input logic [7:0] addr, input logic [7:0] wd,
                        input logic [4:0] evt, input logic ack);
        @(negedge clk);
        sfr_wr = wr; sfr_addr = addr; sfr_wdata = wd; cmp_evt = evt; irq_ack = ack;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_addr = '0; sfr_wdata = '0; cmp_evt = '0; irq_ack = 1'b0;
    endtask

    task automatic rd(input logic [7:0] addr, output logic [7:0] val);
        sfr_rd = 1'b1; sfr_addr = addr;
        #0.5;
        val = sfr_rdata;
        sfr_rd = 1'b0; sfr_addr = '0;
        #0.5;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_MASK, v); check("R1 mask after reset", v, 8'h00);
        rd(A_PEND, v); check("R1 pending after reset", v, 8'h00);
        check("R1 irq_req after reset", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_mask_rw();
        logic [7:0] v;
        step(1, A_MASK, 8'hFF, 5'h00, 0);
        rd(A_MASK, v); check("R2 mask write 0xFF reads 0x1F", v, 8'h1F);
        step(1, A_MASK, 8'h0A, 5'h00, 0);
        rd(A_MASK, v); check("R2 mask write 0x0A", v, 8'h0A);
    endtask

    task automatic t_gated_set();
        logic [7:0] v;
        step(0, 8'h00, 8'h00, 5'h1F, 0);
        rd(A_PEND, v); check("R3 R4 only masked bits latch", v, 8'h0A);
        check("R8 irq_req with pending", {7'd0, irq_req}, 8'h01);
    endtask

    task automatic t_sw_clear();
        logic [7:0] v;
        step(1, A_PEND, 8'hFF, 5'h00, 0);
        rd(A_PEND, v); check("R5 writing ones keeps bits", v, 8'h0A);
        step(1, A_PEND, 8'h08, 5'h00, 0);
        rd(A_PEND, v); check("R5 zero clears bit 1 only", v, 8'h08);
        step(1, A_PEND, 8'h00, 5'h00, 0);
        rd(A_PEND, v); check("R5 zero clears all", v, 8'h00);
        check("R8 irq_req low when empty", {7'd0, irq_req}, 8'h00);
        step(1, A_PEND, 8'h1F, 5'h00, 0);
        rd(A_PEND, v); check("R5 write of ones cannot set", v, 8'h00);
    endtask

    task automatic t_mask_same_cycle();
        logic [7:0] v;
        step(1, A_MASK, 8'h00, 5'h00, 0);
        step(1, A_MASK, 8'h01, 5'h01, 0);
        rd(A_PEND, v); check("R3 old mask used in write cycle", v, 8'h00);
        step(0, 8'h00, 8'h00, 5'h01, 0);
        rd(A_PEND, v); check("R3 new mask gates next event", v, 8'h01);
        step(1, A_PEND, 8'h00, 5'h00, 0);
    endtask

    task automatic t_ack();
        logic [7:0] v;
        step(1, A_MASK, 8'h1F, 5'h00, 0);
        step(0, 8'h00, 8'h00, 5'h15, 0);
        rd(A_PEND, v); check("R3 three events latch", v, 8'h15);
        step(0, 8'h00, 8'h00, 5'h00, 1);
        rd(A_PEND, v); check("R6 acknowledge clears all", v, 8'h00);
        check("R6 irq_req drops", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        step(0, 8'h00, 8'h00, 5'h15, 0);
        step(0, 8'h00, 8'h00, 5'h01, 1);
        rd(A_PEND, v); check("R7 event beats acknowledge", v, 8'h01);
        step(1, A_PEND, 8'h00, 5'h04, 0);
        rd(A_PEND, v); check("R7 event beats zero write", v, 8'h04);
    endtask

    task automatic t_no_remask();
        logic [7:0] v;
        step(0, 8'h00, 8'h00, 5'h10, 0);
        step(1, A_MASK, 8'h00, 5'h00, 0);
        rd(A_PEND, v); check("R8 pending kept after unmask", v, 8'h14);
        check("R8 irq_req stays high", {7'd0, irq_req}, 8'h01);
        step(0, 8'h00, 8'h00, 5'h00, 1);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        step(1, A_MASK, 8'h06, 5'h00, 0);
        step(0, 8'h00, 8'h00, 5'h06, 0);
        check("R9 no read strobe gives zero", sfr_rdata, 8'h00);
        rd(8'h00, v); check("R9 unmapped read zero", v, 8'h00);
        step(1, 8'hB0, 8'h00, 5'h00, 0);
        step(1, 8'hAD, 8'h00, 5'h00, 0);
        rd(A_MASK, v); check("R9 stray write leaves mask", v, 8'h06);
        rd(A_PEND, v); check("R9 stray write leaves pending", v, 8'h06);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_rw();
        t_gated_set();
        t_sw_clear();
        t_mask_same_cycle();
        t_ack();
        t_collision();
        t_no_remask();
        t_decode();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule